// File: doc/BRIEF.md
# Image Sensor Readout Timing Sequencer

This block produces the line-based internal timing for reading a rectangular window out of a pixel array. It steps at one quarter of the input clock rate. On each step it presents one pixel position as a row address and a column address, and it marks the first pixel of every line and of every frame. The window is set by a column start given in 4-pixel kernels, a row start, a line width given as a kernel count, and a frame length given in lines. Either axis can be scanned in mirror order. The row direction can be subsampled so that every other row is read.

While a frame is read out, the block raises a primary reset pulse for a programmed number of lines starting at line 0. It can also raise two optional extra reset pulses, each on one programmed line. A transfer strobe marks the last pixel of the frame. A non-destructive mode is reported on an output, and while that mode is on the two extra reset pulses are held off.

Configuration is written through a simple parallel write port into a pending bank. The pending bank is copied to the active bank only at the boundary between frames, so a frame in progress always runs on one consistent setting.

Top module: `img_seq_timing`

## Requirements
- R1: The sequencer steps once every 4 clock cycles. `pix_valid` is high for exactly one cycle in each group of 4. `line_start`, `frame_start` and `xfer_pulse` are high only in a cycle where `pix_valid` is high.
- R2: A line holds 4×K pixel steps, where K is the kernel count (K=0 means 256). A frame holds F lines, where F is the frame-length value (F=0 means 4096). `line_start` marks pixel 0 of each line, and `frame_start` marks pixel 0 of line 0.
- R3: Pixel i of a line (0-based) has column address (4×X + i) mod 1024 when the X-mirror bit is 0, and (4×X + 4K−1−i) mod 1024 when it is 1. X is the column start.
- R4: Line j of a frame (0-based) has row address (Y + j×s) mod 512 when the Y-mirror bit is 0, and (Y + (F−1−j)×s) mod 512 when it is 1. Y is the row start and s is the row step.
- R5: The row step s is 2 when the subsample bit is set and 1 when it is clear.
- R6: `rst1_pulse` is high during lines j < P, where P is the primary reset length in lines. P=0 never raises it.
- R7: `rst2_pulse` is high during line j = Q2 when its enable bit is set, and `rst3_pulse` is high during line j = Q3 when its enable bit is set.
- R8: `xfer_pulse` is high on the last pixel step of the last line of each frame.
- R9: `ndr_mode` follows the non-destructive bit. While that bit is set, `rst2_pulse` and `rst3_pulse` stay low whatever their enables are.
- R10: A write changes nothing in the frame that is in progress. It takes effect from the next `frame_start`.
- R11: After reset the active and pending banks hold the parameter defaults. The first pixel step comes on the 4th clock after reset is released, and it is a `frame_start`.
- R12: The write port uses these register addresses: 0 = control (bit0 X-mirror, bit1 Y-mirror, bit2 subsample, bit3 enable rst2, bit4 enable rst3, bit5 non-destructive); 1 = X start [7:0]; 2 = Y start [8:0]; 3 = kernel count [7:0]; 4 = primary reset length P; 5 = Q2; 6 = Q3; 7 = frame length F. Registers 4 to 7 are 12 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four times the step rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the pending register bank |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 12 | Write data |
| pix_valid | output | 1 | Pixel step (one cycle in four) |
| line_start | output | 1 | First pixel of a line |
| frame_start | output | 1 | First pixel of a frame |
| row_addr | output | 9 | Current row address |
| col_addr | output | 10 | Current column address |
| rst1_pulse | output | 1 | Primary reset, level over lines 0..P−1 |
| rst2_pulse | output | 1 | Extra reset on line Q2 |
| rst3_pulse | output | 1 | Extra reset on line Q3 |
| xfer_pulse | output | 1 | Frame-transfer strobe on the final pixel |
| ndr_mode | output | 1 | Non-destructive mode is active |

## Verification
The stepping-pattern assertions compare each pixel step with the step 4 clocks earlier. They take it for granted that the configuration does not change inside a line. The shadow bank guarantees this for any write that does not land exactly on the frame-end step. The bench starts its writes a few clocks after a `frame_start` and finishes them well before the frame ends. It then checks that the frame carrying the writes still follows the old setting, and that the next frame follows the new one.

// File: rtl/img_seq_timing.sv
module img_seq_timing #(
  parameter int DIV            = 4,
  parameter int DEF_START_X    = 0,
  parameter int DEF_START_Y    = 0,
  parameter int DEF_KERNELS    = 160,
  parameter int DEF_RST1_LINES = 2,
  parameter int DEF_RST2_LINE  = 0,
  parameter int DEF_RST3_LINE  = 0,
  parameter int DEF_XFER_LINE  = 481
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [11:0] cfg_wdata,
  output logic        pix_valid,
  output logic        line_start,
  output logic        frame_start,
  output logic [8:0]  row_addr,
  output logic [9:0]  col_addr,
  output logic        rst1_pulse,
  output logic        rst2_pulse,
  output logic        rst3_pulse,
  output logic        xfer_pulse,
  output logic        ndr_mode
);
  localparam int DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int NREG = 8;

  function automatic logic [11:0] dflt(input int idx);
    case (idx)
      1:       return 12'(DEF_START_X);
      2:       return 12'(DEF_START_Y);
      3:       return 12'(DEF_KERNELS);
      4:       return 12'(DEF_RST1_LINES);
      5:       return 12'(DEF_RST2_LINE);
      6:       return 12'(DEF_RST3_LINE);
      7:       return 12'(DEF_XFER_LINE);
      default: return 12'd0;
    endcase
  endfunction

  logic [DW-1:0] div;
  logic [11:0]   p_cfg [NREG];
  logic [11:0]   a_cfg [NREG];
  logic [9:0]    pix;
  logic [11:0]   line;

  wire        tick  = (div == DW'(DIV - 1));
  wire        rev_x = a_cfg[0][0];
  wire        rev_y = a_cfg[0][1];
  wire        sub_y = a_cfg[0][2];
  wire        en2   = a_cfg[0][3];
  wire        en3   = a_cfg[0][4];
  wire        ndr   = a_cfg[0][5];
  wire [9:0]  w_m1  = {a_cfg[3][7:0], 2'b00} - 10'd1;
  wire [11:0] l_m1  = a_cfg[7] - 12'd1;

  wire line_end  = (pix == w_m1);
  wire frame_end = line_end && (line == l_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else        div <= tick ? '0 : div + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        p_cfg[i] <= dflt(i);
        a_cfg[i] <= dflt(i);
      end
    end else begin
      if (cfg_we) p_cfg[cfg_addr] <= cfg_wdata;
      if (tick && frame_end)
        for (int i = 0; i < NREG; i++) a_cfg[i] <= p_cfg[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix  <= '0;
      line <= '0;
    end else if (tick) begin
      if (line_end) begin
        pix  <= '0;
        line <= frame_end ? 12'd0 : line + 12'd1;
      end else begin
        pix <= pix + 10'd1;
      end
    end
  end

  wire [9:0]  col_idx  = rev_x ? (w_m1 - pix) : pix;
  wire [11:0] row_idx  = rev_y ? (l_m1 - line) : line;
  wire [11:0] row_step = sub_y ? {row_idx[10:0], 1'b0} : row_idx;

  assign col_addr    = {a_cfg[1][7:0], 2'b00} + col_idx;
  assign row_addr    = a_cfg[2][8:0] + row_step[8:0];
  assign pix_valid   = tick;
  assign line_start  = tick && (pix == 10'd0);
  assign frame_start = line_start && (line == 12'd0);
  assign xfer_pulse  = tick && frame_end;
  assign rst1_pulse  = (line < a_cfg[4]);
  assign rst2_pulse  = en2 && !ndr && (line == a_cfg[5]);
  assign rst3_pulse  = en3 && !ndr && (line == a_cfg[6]);
  assign ndr_mode    = ndr;
endmodule

module img_seq_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_valid,
  input logic       line_start,
  input logic       frame_start,
  input logic       xfer_pulse,
  input logic       rst1_pulse,
  input logic [8:0] row_addr,
  input logic [9:0] col_addr
);
  a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  a_r1_step_period: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##4 pix_valid);

  a_r2_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_start && pix_valid));

  a_r8_xfer_then_frame: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pulse |-> ##4 frame_start);

  a_r3_col_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start) |->
      ((col_addr == $past(col_addr, 4) + 10'd1) || (col_addr == $past(col_addr, 4) - 10'd1)));

  a_r4_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start) |-> (row_addr == $past(row_addr, 4)));

  a_r6_rst1_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start) |-> (rst1_pulse == $past(rst1_pulse, 4)));
endmodule

bind img_seq_timing img_seq_timing_chk u_chk (.*);

// File: tb/img_seq_timing_bench.sv
module img_seq_timing_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEF_K  = 2;
  localparam int  DEF_F  = 5;
  localparam int  WD_MAX = 150000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic        pix_valid, line_start, frame_start, xfer_pulse, ndr_mode;
  logic        rst1_pulse, rst2_pulse, rst3_pulse;
  logic [8:0]  row_addr;
  logic [9:0]  col_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cur [8];
  int nxt [8];

  img_seq_timing #(.DEF_KERNELS(DEF_K), .DEF_XFER_LINE(DEF_F)) u_img_seq_timing (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    cfg_we    = 1;
    cfg_addr  = 3'(a);
    cfg_wdata = 12'(d);
    nxt[a]    = d & 12'hFFF;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic walk_frame(input string ctx);
    int w, l, steps, bit_ctl;
    w = ((cur[3] & 255) == 0) ? 1024 : 4 * (cur[3] & 255);
    l = (cur[7] == 0) ? 4096 : cur[7];
    bit_ctl = cur[0];
    steps = w * l;
    for (int t = 0; t < steps; t++) begin
      int gap, pix, ln, ix, iy, step, er, ec;
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
        if (!pix_valid) begin
          chk({"R1 strobe idle ", ctx}, {line_start, frame_start, xfer_pulse}, 0);
        end
      end while (!pix_valid);
      if (t > 0) chk({"R1 step gap ", ctx}, gap, 4);
      pix  = t % w;
      ln   = t / w;
      ix   = bit_ctl[0] ? (w - 1 - pix) : pix;
      step = bit_ctl[2] ? 2 : 1;
      iy   = bit_ctl[1] ? (l - 1 - ln) : ln;
      ec   = (4 * (cur[1] & 255) + ix) % 1024;
      er   = ((cur[2] & 511) + iy * step) % 512;
      chk({"R2 line_start ", ctx}, line_start, pix == 0);
      chk({"R2 frame_start ", ctx}, frame_start, t == 0);
      chk({"R3 col ", ctx}, col_addr, ec);
      chk({"R4/R5 row ", ctx}, row_addr, er);
      chk({"R6 rst1 ", ctx}, rst1_pulse, ln < cur[4]);
      chk({"R7/R9 rst2 ", ctx}, rst2_pulse, bit_ctl[3] && !bit_ctl[5] && ln == cur[5]);
      chk({"R7/R9 rst3 ", ctx}, rst3_pulse, bit_ctl[4] && !bit_ctl[5] && ln == cur[6]);
      chk({"R8 xfer ", ctx}, xfer_pulse, t == steps - 1);
      chk({"R9 ndr_mode ", ctx}, ndr_mode, bit_ctl[5]);
    end
  endtask

  task automatic t_reset;
    cur = '{0, 0, 0, DEF_K, 2, 0, 0, DEF_F};
    nxt = cur;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R11 idle after release", pix_valid, 0);
    @(negedge clk); chk("R11 idle clk1", pix_valid, 0);
    @(negedge clk); chk("R11 idle clk2", pix_valid, 0);
    walk_frame("R11 defaults");
  endtask

  task automatic t_forward;
    fork
      walk_frame("R10 old setting");
      begin
        repeat (2) @(negedge clk);
        cfg_write(0, 8); cfg_write(1, 3); cfg_write(2, 10); cfg_write(3, 3);
        cfg_write(7, 7); cfg_write(4, 3); cfg_write(5, 4);
      end
    join
    cur = nxt;
    walk_frame("forward R12");
  endtask

  task automatic t_reverse;
    fork
      walk_frame("R10 old setting");
      begin
        repeat (2) @(negedge clk);
        cfg_write(0, 19); cfg_write(1, 1); cfg_write(2, 20); cfg_write(3, 1);
        cfg_write(7, 4); cfg_write(4, 1); cfg_write(6, 1);
      end
    join
    cur = nxt;
    walk_frame("mirror");
  endtask

  task automatic t_subsample;
    fork
      walk_frame("R10 old setting");
      begin
        repeat (2) @(negedge clk);
        cfg_write(0, 4); cfg_write(1, 255); cfg_write(2, 505); cfg_write(3, 2);
        cfg_write(7, 6);
      end
    join
    cur = nxt;
    walk_frame("R5 subsample wrap");
  endtask

  task automatic t_ndr;
    fork
      walk_frame("R10 old setting");
      begin
        repeat (2) @(negedge clk);
        cfg_write(0, 56); cfg_write(5, 0); cfg_write(6, 1); cfg_write(3, 2);
        cfg_write(7, 3);
      end
    join
    cur = nxt;
    walk_frame("R9 non-destructive");
  endtask

  task automatic t_wide;
    fork
      walk_frame("R10 old setting");
      begin
        repeat (2) @(negedge clk);
        cfg_write(0, 0); cfg_write(1, 0); cfg_write(2, 0); cfg_write(3, 0);
        cfg_write(7, 2); cfg_write(4, 0);
      end
    join
    cur = nxt;
    walk_frame("R2 zero kernels R6 no reset");
  endtask

  initial begin : watchdog
    repeat (WD_MAX) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_MAX);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    t_reset();
    t_forward();
    t_reverse();
    t_subsample();
    t_ndr();
    t_wide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule